// File: doc/BRIEF.md
# DDR SDRAM Command Spacing Checker

This block watches the command stream issued to a four-bank DDR SDRAM. It flags every command that comes too early after an earlier one under the minimum-spacing rules of the memory. It holds one down-counting timer per bank and per rule, plus shared timers for the rules that span all banks. A command that breaks a rule produces a one-cycle violation pulse with a reason code one clock later. It also updates the timers exactly as a legal command would, so the checks that follow stay consistent.

Every timer length is set in nanoseconds and a clock period in picoseconds. Each length is rounded up to whole cycles, and the defaults assume a 5 ns memory clock. Gaps that depend on burst length use the burst-length select that is present with the write or read. The write-to-reactivate gap is the sum of two separately rounded terms: write recovery and precharge. Per-bank ready vectors show which command classes would pass all checks if issued in the current cycle. A free-running interval counter raises a refresh-due flag.

Top module: `ddr_cmd_timing_chk`

## Requirements
- R1: After reset, viol_o is 0, every bit of every ready output is 1, and ref_due_o is 0.
- R2: An ACT is flagged if it comes fewer than 12 cycles after an ACT to the same bank (reason 4), fewer than 2 cycles after an ACT to any bank (reason 5), or fewer than 4 cycles after a precharge of its bank (reason 6).
- R3: An ACT or REF fewer than 14 cycles after a REF is flagged with reason 3. Any command fewer than 2 cycles after an MRS is flagged with reason 1.
- R4: A RD or WR fewer than 4 cycles after an ACT to the same bank is flagged with reason 7.
- R5: A precharge of a bank is flagged in three cases. Fewer than 8 cycles after its ACT gives reason 8. Fewer than 4+BL/2 cycles after a WR to it gives reason 9. Fewer than BL/2 cycles after a RD to it gives reason 10. PREALL is checked against every bank.
- R6: A RD fewer than 2+BL/2 cycles after a WR gives reason 11. A WR fewer than 3+BL/2 cycles after a RD gives reason 12. A WR fewer than 3 cycles after a BST gives reason 13. Burst-length select bl_sel_i is 0 for BL2, 1 for BL4, and 2 or 3 for BL8.
- R7: After SREX, a command other than RD is flagged with reason 2 if it comes within 15 cycles. A RD is flagged with reason 2 if it comes within 200 cycles.
- R8: An ACT fewer than 7 cycles after a WR to the same bank is flagged with reason 14. The 7 is the rounded write recovery plus the rounded precharge time.
- R9: A bank left open for more than 24000 cycles raises reason 15 exactly once. This happens in the cycle after its 24000th open cycle, unless a precharge lands in that cycle.
- R10: Violations are reported on viol_o and reason_o one cycle after the command. When several rules fail in the same cycle, the lowest reason code is reported. A flagged command still updates the timers.
- R11: act_ok_o, rd_ok_o, wr_ok_o and pre_ok_o hold one bit per bank. ref_ok_o and mrs_ok_o are single bits. A bit is 1 when a command of that class, issued in the current cycle, would pass every spacing rule.
- R12: ref_due_o rises after every 3120 cycles since reset and falls the cycle after a REF.
- R13: Command codes are NOP=0, ACT=1, RD=2, WR=3, PRE=4, PREALL=5, REF=6, MRS=7, BST=8, SREX=9. Codes 10 to 15, and any code with cmd_vld_i low, have no effect and are never flagged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_vld_i | input | 1 | Command present this cycle |
| cmd_i | input | 4 | Command code |
| bank_i | input | 2 | Target bank |
| bl_sel_i | input | 2 | Burst-length select |
| viol_o | output | 1 | Spacing violation pulse |
| reason_o | output | 4 | Reason code of the reported violation |
| act_ok_o | output | 4 | ACT legal per bank |
| rd_ok_o | output | 4 | RD legal per bank |
| wr_ok_o | output | 4 | WR legal per bank |
| pre_ok_o | output | 4 | Precharge legal per bank |
| ref_ok_o | output | 1 | REF legal |
| mrs_ok_o | output | 1 | MRS legal |
| ref_due_o | output | 1 | Refresh interval elapsed |

## Verification
The open-too-long expiry of a bank and a command-driven violation can fall in the same cycle. To provoke this, bank 0 is opened, then after almost 24000 idle cycles an MRS is followed by a REF. That REF lands exactly on bank 0's expiry cycle. The judgement is that the single pulse carries reason 1, not 15, and that bank 0's expiry is not reported again. Bank 1 was opened two cycles after bank 0, and its own expiry then shows reason 15 on its own. Several other scenarios also break two rules at once and expect the lower code.

// File: rtl/ddr_chk_pkg.sv
package ddr_chk_pkg;
  localparam logic [3:0] CMD_NOP  = 4'd0;
  localparam logic [3:0] CMD_ACT  = 4'd1;
  localparam logic [3:0] CMD_RD   = 4'd2;
  localparam logic [3:0] CMD_WR   = 4'd3;
  localparam logic [3:0] CMD_PRE  = 4'd4;
  localparam logic [3:0] CMD_PREA = 4'd5;
  localparam logic [3:0] CMD_REF  = 4'd6;
  localparam logic [3:0] CMD_MRS  = 4'd7;
  localparam logic [3:0] CMD_BST  = 4'd8;
  localparam logic [3:0] CMD_SREX = 4'd9;

  // reason codes double as priority: lower value wins
  localparam int RSN_MRD    = 1;
  localparam int RSN_SREX   = 2;
  localparam int RSN_RFC    = 3;
  localparam int RSN_RC     = 4;
  localparam int RSN_RRD    = 5;
  localparam int RSN_RP     = 6;
  localparam int RSN_RCD    = 7;
  localparam int RSN_RAS    = 8;
  localparam int RSN_WPD    = 9;
  localparam int RSN_RPD    = 10;
  localparam int RSN_WTR    = 11;
  localparam int RSN_RTW    = 12;
  localparam int RSN_BSTW   = 13;
  localparam int RSN_DAL    = 14;
  localparam int RSN_RASMAX = 15;

  // nanoseconds to whole cycles, rounded up
  function automatic int ns_to_cyc(input int ns, input int tck_ps);
    return (ns * 1000 + tck_ps - 1) / tck_ps;
  endfunction

  // half the burst length for a burst-length select
  function automatic int bl_half(input logic [1:0] sel);
    case (sel)
      2'd0:    return 1;
      2'd1:    return 2;
      default: return 4;
    endcase
  endfunction

  // lowest set bit above bit 0, or zero
  function automatic logic [3:0] first_reason(input logic [15:0] v);
    logic [3:0] r;
    r = 4'd0;
    for (int i = 15; i >= 1; i--) begin
      if (v[i]) r = 4'(i);
    end
    return r;
  endfunction
endpackage

// File: rtl/ddr_chk_timer.sv
module ddr_chk_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load_i,
  input  logic [W-1:0] len_i,
  output logic         ok_o
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (load_i)         cnt <= (len_i == '0) ? '0 : len_i - 1'b1;
    else if (cnt != '0)      cnt <= cnt - 1'b1;
  end

  assign ok_o = (cnt == '0);

  AST_TIMER_BLOCKS_NEXT: assert property (@(posedge clk) disable iff (!rst_n)
    load_i && (len_i > W'(1)) |=> !ok_o); // R11
endmodule

// File: rtl/ddr_chk_bank.sv
module ddr_chk_bank #(
  parameter int CW      = 8,
  parameter int T_RC    = 12,
  parameter int T_RCD   = 4,
  parameter int T_RAS   = 8,
  parameter int T_RP    = 4,
  parameter int T_DAL   = 7,
  parameter int RAS_MAX = 24000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          act_i,
  input  logic          rd_i,
  input  logic          wr_i,
  input  logic          pre_i,
  input  logic [CW-1:0] blh_i,
  output logic          rc_ok_o,
  output logic          rcd_ok_o,
  output logic          ras_ok_o,
  output logic          rp_ok_o,
  output logic          wpd_ok_o,
  output logic          rpd_ok_o,
  output logic          dal_ok_o,
  output logic          hit_o
);
  localparam int NT    = 7;
  localparam int AGE_W = $clog2(RAS_MAX + 2);
  localparam int TI_RC = 0, TI_RCD = 1, TI_RAS = 2, TI_RP = 3;
  localparam int TI_WPD = 4, TI_RPD = 5, TI_DAL = 6;

  logic [NT-1:0] ld, ok;
  logic [CW-1:0] len [NT];

  always_comb begin
    ld[TI_RC]  = act_i;  len[TI_RC]  = CW'(T_RC);
    ld[TI_RCD] = act_i;  len[TI_RCD] = CW'(T_RCD);
    ld[TI_RAS] = act_i;  len[TI_RAS] = CW'(T_RAS);
    ld[TI_RP]  = pre_i;  len[TI_RP]  = CW'(T_RP);
    ld[TI_WPD] = wr_i;   len[TI_WPD] = CW'(4) + blh_i;
    ld[TI_RPD] = rd_i;   len[TI_RPD] = blh_i;
    ld[TI_DAL] = wr_i;   len[TI_DAL] = CW'(T_DAL);
  end

  for (genvar t = 0; t < NT; t++) begin : g_tmr
    ddr_chk_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(ld[t]), .len_i(len[t]), .ok_o(ok[t]));
  end

  assign rc_ok_o  = ok[TI_RC];
  assign rcd_ok_o = ok[TI_RCD];
  assign ras_ok_o = ok[TI_RAS];
  assign rp_ok_o  = ok[TI_RP];
  assign wpd_ok_o = ok[TI_WPD];
  assign rpd_ok_o = ok[TI_RPD];
  assign dal_ok_o = ok[TI_DAL];

  // open-row age: 1 in the cycle after ACT, saturating one past the limit
  logic             open_q;
  logic [AGE_W-1:0] age_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (act_i) begin
      open_q <= 1'b1;
      age_q  <= AGE_W'(1);
    end else if (pre_i) begin
      open_q <= 1'b0;
      age_q  <= '0;
    end else if (open_q && age_q <= AGE_W'(RAS_MAX)) begin
      age_q  <= age_q + 1'b1;
    end
  end

  assign hit_o = open_q && (age_q == AGE_W'(RAS_MAX)) && !pre_i;

  AST_RASMAX_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
    hit_o |=> !hit_o); // R9
  AST_ACT_HOLDS_ROW: assert property (@(posedge clk) disable iff (!rst_n)
    act_i |=> !ras_ok_o && !rcd_ok_o); // R5
endmodule

// File: rtl/ddr_chk_refresh.sv
module ddr_chk_refresh #(
  parameter int REFI = 3120
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_i,
  output logic due_o
);
  localparam int RW = $clog2(REFI);
  logic [RW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == RW'(REFI - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      due_o <= 1'b0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (wrap)       due_o <= 1'b1;
      else if (ref_i) due_o <= 1'b0;
    end
  end

  AST_REF_CLEARS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    ref_i && !wrap |=> !due_o); // R12
  AST_WRAP_SETS_DUE: assert property (@(posedge clk) disable iff (!rst_n)
    wrap |=> due_o); // R12
endmodule

// File: rtl/ddr_cmd_timing_chk.sv
module ddr_cmd_timing_chk
  import ddr_chk_pkg::*;
#(
  parameter int NB           = 4,
  parameter int TCK_PS       = 5000,
  parameter int T_RC_NS      = 60,
  parameter int T_RFC_NS     = 70,
  parameter int T_RAS_NS     = 40,
  parameter int T_RASMAX_NS  = 120000,
  parameter int T_RCD_NS     = 18,
  parameter int T_RP_NS      = 18,
  parameter int T_RRD_NS     = 10,
  parameter int T_WR_NS      = 15,
  parameter int T_REFI_NS    = 15600,
  parameter int T_MRD        = 2,
  parameter int T_XSNR       = 15,
  parameter int T_XSRD       = 200,
  parameter int T_BSTW       = 3,
  parameter int CW           = 8,
  localparam int BAW         = (NB > 1) ? $clog2(NB) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cmd_vld_i,
  input  logic [3:0]     cmd_i,
  input  logic [BAW-1:0] bank_i,
  input  logic [1:0]     bl_sel_i,
  output logic           viol_o,
  output logic [3:0]     reason_o,
  output logic [NB-1:0]  act_ok_o,
  output logic [NB-1:0]  rd_ok_o,
  output logic [NB-1:0]  wr_ok_o,
  output logic [NB-1:0]  pre_ok_o,
  output logic           ref_ok_o,
  output logic           mrs_ok_o,
  output logic           ref_due_o
);
  localparam int C_RC     = ns_to_cyc(T_RC_NS, TCK_PS);
  localparam int C_RFC    = ns_to_cyc(T_RFC_NS, TCK_PS);
  localparam int C_RAS    = ns_to_cyc(T_RAS_NS, TCK_PS);
  localparam int C_RASMAX = ns_to_cyc(T_RASMAX_NS, TCK_PS);
  localparam int C_RCD    = ns_to_cyc(T_RCD_NS, TCK_PS);
  localparam int C_RP     = ns_to_cyc(T_RP_NS, TCK_PS);
  localparam int C_RRD    = ns_to_cyc(T_RRD_NS, TCK_PS);
  localparam int C_DAL    = ns_to_cyc(T_WR_NS, TCK_PS) + ns_to_cyc(T_RP_NS, TCK_PS);
  localparam int C_REFI   = ns_to_cyc(T_REFI_NS, TCK_PS);
  localparam int NG = 8;
  localparam int GI_MRD = 0, GI_XSNR = 1, GI_XSRD = 2, GI_RFC = 3;
  localparam int GI_RRD = 4, GI_WTR = 5, GI_RTW = 6, GI_BSTW = 7;

  // decoded command events
  logic is_act, is_rd, is_wr, is_pre, is_prea, is_ref, is_mrs, is_bst, is_srex, is_any;
  assign is_act  = cmd_vld_i && (cmd_i == CMD_ACT);
  assign is_rd   = cmd_vld_i && (cmd_i == CMD_RD);
  assign is_wr   = cmd_vld_i && (cmd_i == CMD_WR);
  assign is_pre  = cmd_vld_i && (cmd_i == CMD_PRE);
  assign is_prea = cmd_vld_i && (cmd_i == CMD_PREA);
  assign is_ref  = cmd_vld_i && (cmd_i == CMD_REF);
  assign is_mrs  = cmd_vld_i && (cmd_i == CMD_MRS);
  assign is_bst  = cmd_vld_i && (cmd_i == CMD_BST);
  assign is_srex = cmd_vld_i && (cmd_i == CMD_SREX);
  assign is_any  = cmd_vld_i && (cmd_i != CMD_NOP) && (cmd_i <= CMD_SREX);

  logic [CW-1:0] blh;
  assign blh = CW'(bl_half(bl_sel_i));

  // shared timers
  logic [NG-1:0] g_ld, g_ok;
  logic [CW-1:0] g_len [NG];

  always_comb begin
    g_ld[GI_MRD]  = is_mrs;   g_len[GI_MRD]  = CW'(T_MRD);
    g_ld[GI_XSNR] = is_srex;  g_len[GI_XSNR] = CW'(T_XSNR);
    g_ld[GI_XSRD] = is_srex;  g_len[GI_XSRD] = CW'(T_XSRD);
    g_ld[GI_RFC]  = is_ref;   g_len[GI_RFC]  = CW'(C_RFC);
    g_ld[GI_RRD]  = is_act;   g_len[GI_RRD]  = CW'(C_RRD);
    g_ld[GI_WTR]  = is_wr;    g_len[GI_WTR]  = CW'(2) + blh;
    g_ld[GI_RTW]  = is_rd;    g_len[GI_RTW]  = CW'(3) + blh;
    g_ld[GI_BSTW] = is_bst;   g_len[GI_BSTW] = CW'(T_BSTW);
  end

  for (genvar g = 0; g < NG; g++) begin : g_glb
    ddr_chk_timer #(.W(CW)) u_tmr (
      .clk(clk), .rst_n(rst_n), .load_i(g_ld[g]), .len_i(g_len[g]), .ok_o(g_ok[g]));
  end

  // per-bank trackers
  logic [NB-1:0] sel, pre_vec;
  logic [NB-1:0] rc_ok, rcd_ok, ras_ok, rp_ok, wpd_ok, rpd_ok, dal_ok, rasmax_hit;

  for (genvar b = 0; b < NB; b++) begin : g_bank
    assign sel[b]     = (bank_i == BAW'(b));
    assign pre_vec[b] = is_prea || (is_pre && sel[b]);
    ddr_chk_bank #(
      .CW(CW), .T_RC(C_RC), .T_RCD(C_RCD), .T_RAS(C_RAS), .T_RP(C_RP),
      .T_DAL(C_DAL), .RAS_MAX(C_RASMAX)
    ) u_bank (
      .clk(clk), .rst_n(rst_n),
      .act_i(is_act && sel[b]), .rd_i(is_rd && sel[b]), .wr_i(is_wr && sel[b]),
      .pre_i(pre_vec[b]), .blh_i(blh),
      .rc_ok_o(rc_ok[b]), .rcd_ok_o(rcd_ok[b]), .ras_ok_o(ras_ok[b]), .rp_ok_o(rp_ok[b]),
      .wpd_ok_o(wpd_ok[b]), .rpd_ok_o(rpd_ok[b]), .dal_ok_o(dal_ok[b]),
      .hit_o(rasmax_hit[b]));
  end

  // rule checks, one bit per reason code
  logic [15:0] v;
  always_comb begin
    v = '0;
    v[RSN_MRD]    = is_any && !g_ok[GI_MRD];
    v[RSN_SREX]   = (is_any && !is_rd && !g_ok[GI_XSNR]) || (is_rd && !g_ok[GI_XSRD]);
    v[RSN_RFC]    = (is_act || is_ref) && !g_ok[GI_RFC];
    v[RSN_RC]     = is_act && |(sel & ~rc_ok);
    v[RSN_RRD]    = is_act && !g_ok[GI_RRD];
    v[RSN_RP]     = is_act && |(sel & ~rp_ok);
    v[RSN_RCD]    = (is_rd || is_wr) && |(sel & ~rcd_ok);
    v[RSN_RAS]    = |(pre_vec & ~ras_ok);
    v[RSN_WPD]    = |(pre_vec & ~wpd_ok);
    v[RSN_RPD]    = |(pre_vec & ~rpd_ok);
    v[RSN_WTR]    = is_rd && !g_ok[GI_WTR];
    v[RSN_RTW]    = is_wr && !g_ok[GI_RTW];
    v[RSN_BSTW]   = is_wr && !g_ok[GI_BSTW];
    v[RSN_DAL]    = is_act && |(sel & ~dal_ok);
    v[RSN_RASMAX] = |rasmax_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      viol_o   <= 1'b0;
      reason_o <= 4'd0;
    end else begin
      viol_o   <= |v;
      reason_o <= first_reason(v);
    end
  end

  // ready vectors from the registered timers
  logic glb_cmd_ok;
  assign glb_cmd_ok = g_ok[GI_MRD] && g_ok[GI_XSNR];
  assign act_ok_o = {NB{glb_cmd_ok && g_ok[GI_RFC] && g_ok[GI_RRD]}} & rc_ok & rp_ok & dal_ok;
  assign rd_ok_o  = {NB{g_ok[GI_MRD] && g_ok[GI_XSRD] && g_ok[GI_WTR]}} & rcd_ok;
  assign wr_ok_o  = {NB{glb_cmd_ok && g_ok[GI_RTW] && g_ok[GI_BSTW]}} & rcd_ok;
  assign pre_ok_o = {NB{glb_cmd_ok}} & ras_ok & wpd_ok & rpd_ok;
  assign ref_ok_o = glb_cmd_ok && g_ok[GI_RFC];
  assign mrs_ok_o = glb_cmd_ok;

  ddr_chk_refresh #(.REFI(C_REFI)) u_ref (
    .clk(clk), .rst_n(rst_n), .ref_i(is_ref), .due_o(ref_due_o));

  AST_READY_ACT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    is_act && act_ok_o[bank_i] && !(|rasmax_hit) |=> !viol_o); // R11
  AST_READY_WR_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
    is_wr && wr_ok_o[bank_i] && !(|rasmax_hit) |=> !viol_o); // R11
  AST_ACT_BLOCKS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |=> (act_ok_o == '0)); // R2
  AST_MRS_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    is_mrs |=> !mrs_ok_o && !ref_ok_o); // R3
  AST_VIOL_CODED: assert property (@(posedge clk) disable iff (!rst_n)
    viol_o |-> (reason_o != 4'd0)); // R10
endmodule

// File: tb/ddr_cmd_timing_chk_test.sv
module ddr_cmd_timing_chk_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_vld_i = 1'b0;
  logic [3:0] cmd_i = 4'd0;
  logic [1:0] bank_i = 2'd0;
  logic [1:0] bl_sel_i = 2'd1;
  logic       viol_o, ref_ok_o, mrs_ok_o, ref_due_o;
  logic [3:0] reason_o, act_ok_o, rd_ok_o, wr_ok_o, pre_ok_o;

  localparam int NOP = 0, ACT = 1, RD = 2, WR = 3, PRE = 4, PREA = 5;
  localparam int REF = 6, MRS = 7, BST = 8, SREX = 9;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  int    q_rsn[$];
  bit    q_chk[$];
  string q_tag[$];

  ddr_cmd_timing_chk uut (
    .clk(clk), .rst_n(rst_n), .cmd_vld_i(cmd_vld_i), .cmd_i(cmd_i), .bank_i(bank_i),
    .bl_sel_i(bl_sel_i), .viol_o(viol_o), .reason_o(reason_o), .act_ok_o(act_ok_o),
    .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o), .pre_ok_o(pre_ok_o), .ref_ok_o(ref_ok_o),
    .mrs_ok_o(mrs_ok_o), .ref_due_o(ref_due_o));

  always #2 clk = ~clk;

  always @(posedge clk) if (rst_n) cyc <= cyc + 1;

  task automatic finish_up();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic check(input string tag, input int got, input int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, got, exp);
    end
  endtask

  // monitor: compare the pulse produced by each driven cycle
  always @(posedge clk) begin
    int    e;
    bit    c;
    string t;
    #1;
    if (rst_n && q_rsn.size() > 0) begin
      e = q_rsn.pop_front();
      c = q_chk.pop_front();
      t = q_tag.pop_front();
      if (c) check(t, viol_o ? int'(reason_o) : 0, e);
    end
  end

  task automatic send(input int c, input int b, input int rsn, input bit chk, input string tag);
    @(negedge clk);
    cmd_vld_i = (c != NOP);
    cmd_i     = c[3:0];
    bank_i    = b[1:0];
    q_rsn.push_back(rsn);
    q_chk.push_back(chk);
    q_tag.push_back(tag);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) send(NOP, 0, 0, 1'b0, "");
  endtask

  task automatic settle();
    idle(20);
    send(PREA, 0, 0, 1'b0, "");
    idle(20);
  endtask

  initial begin
    #(4 * 190000);
    errors++;
    $display("FAIL watchdog expired actual 0 expected 1");
    finish_up();
  end

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check("R1 viol", int'(viol_o), 0);
    check("R1 act_ok", int'(act_ok_o), 15);
    check("R1 rd/wr/pre ok", int'({rd_ok_o, wr_ok_o, pre_ok_o}), 12'hfff);
    check("R1 ref/mrs ok", int'({ref_ok_o, mrs_ok_o}), 3);
    check("R1 ref_due", int'(ref_due_o), 0);

    // R12 refresh interval
    while (cyc < 3119) send(NOP, 0, 0, 1'b0, "");
    check("R12 due before interval", int'(ref_due_o), 0);
    send(NOP, 0, 0, 1'b0, "");
    check("R12 due at interval", int'(ref_due_o), 1);
    send(REF, 0, 0, 1'b1, "R12 ref");
    send(NOP, 0, 0, 1'b0, "");
    check("R12 due cleared", int'(ref_due_o), 0);
    settle();

    // R11 ready vectors after ACT to bank 0
    send(ACT, 0, 0, 1'b1, "R11 act");
    send(NOP, 0, 0, 1'b0, "");
    check("R11 act_ok c1", int'(act_ok_o), 0);
    send(NOP, 0, 0, 1'b0, "");
    check("R11 act_ok c2", int'(act_ok_o), 4'b1110);
    send(NOP, 0, 0, 1'b0, "");
    check("R11 rd_ok c3", int'(rd_ok_o), 4'b1110);
    send(NOP, 0, 0, 1'b0, "");
    check("R11 rd_ok c4", int'(rd_ok_o), 4'b1111);
    settle();

    // R2 RRD, then R10 flagged ACT still opens bank 1
    send(ACT, 0, 0, 1'b1, "R2 act b0");
    send(ACT, 1, 5, 1'b1, "R2 rrd");
    send(NOP, 0, 0, 1'b0, "");
    send(RD, 1, 7, 1'b1, "R10 state after flagged act");
    settle();
    send(ACT, 0, 0, 1'b1, "R2 act b0");
    idle(1);
    send(ACT, 1, 0, 1'b1, "R2 rrd boundary");
    settle();

    // R2 RC and RP together: R10 lower code wins
    send(ACT, 0, 0, 1'b1, "R2 act");
    idle(7);
    send(PRE, 0, 0, 1'b1, "R5 ras boundary");
    idle(2);
    send(ACT, 0, 4, 1'b1, "R10 rc over rp");
    settle();
    send(ACT, 0, 0, 1'b1, "R2 act");
    idle(7);
    send(PRE, 0, 0, 1'b1, "R5 pre");
    idle(3);
    send(ACT, 0, 0, 1'b1, "R2 rc/rp boundary");
    settle();

    // R5 RAS
    send(ACT, 2, 0, 1'b1, "R5 act");
    idle(6);
    send(PRE, 2, 8, 1'b1, "R5 ras");
    settle();

    // R4 RCD
    send(ACT, 0, 0, 1'b1, "R4 act");
    idle(2);
    send(RD, 0, 7, 1'b1, "R4 rcd");
    settle();
    send(ACT, 0, 0, 1'b1, "R4 act");
    idle(3);
    send(WR, 0, 0, 1'b1, "R4 rcd boundary");
    settle();

    // R5 WPD with BL4
    send(ACT, 0, 0, 1'b1, "R5 act");
    idle(3);
    send(WR, 0, 0, 1'b1, "R5 wr");
    idle(4);
    send(PRE, 0, 9, 1'b1, "R5 wpd");
    settle();
    send(ACT, 0, 0, 1'b1, "R5 act");
    idle(3);
    send(WR, 0, 0, 1'b1, "R5 wr");
    idle(5);
    send(PRE, 0, 0, 1'b1, "R5 wpd boundary");
    settle();

    // R5 RAS and RPD together, then RPD through PREALL
    send(ACT, 0, 0, 1'b1, "R5 act");
    idle(3);
    send(RD, 0, 0, 1'b1, "R5 rd");
    send(PRE, 0, 8, 1'b1, "R10 ras over rpd");
    settle();
    send(ACT, 0, 0, 1'b1, "R5 act");
    idle(6);
    send(RD, 0, 0, 1'b1, "R5 rd");
    send(PREA, 0, 10, 1'b1, "R5 rpd prealL");
    settle();

    // R6 WTR with BL8
    bl_sel_i = 2'd2;
    send(ACT, 0, 0, 1'b1, "R6 act");
    idle(3);
    send(WR, 0, 0, 1'b1, "R6 wr bl8");
    idle(4);
    send(RD, 0, 11, 1'b1, "R6 wtr bl8");
    send(RD, 0, 0, 1'b1, "R6 wtr boundary");
    bl_sel_i = 2'd1;
    settle();

    // R6 RTW with BL4
    send(ACT, 0, 0, 1'b1, "R6 act");
    idle(3);
    send(RD, 0, 0, 1'b1, "R6 rd");
    idle(3);
    send(WR, 0, 12, 1'b1, "R6 rtw");
    send(WR, 0, 0, 1'b1, "R6 rtw boundary");
    settle();

    // R6 BST to WR
    send(ACT, 0, 0, 1'b1, "R6 act");
    idle(3);
    send(BST, 0, 0, 1'b1, "R6 bst");
    idle(1);
    send(WR, 0, 13, 1'b1, "R6 bstw");
    send(WR, 0, 0, 1'b1, "R6 bstw boundary");
    settle();

    // R3 MRS spacing and ready
    send(MRS, 0, 0, 1'b1, "R3 mrs");
    send(REF, 0, 1, 1'b1, "R3 mrd");
    check("R3 mrs_ok c1", int'(mrs_ok_o), 0);
    send(NOP, 0, 0, 1'b0, "");
    check("R3 mrs_ok c2", int'(mrs_ok_o), 1);
    settle();

    // R13 unused code after MRS is not a command
    send(MRS, 0, 0, 1'b1, "R13 mrs");
    send(12, 0, 0, 1'b1, "R13 code 12 ignored");
    send(11, 3, 0, 1'b1, "R13 code 11 ignored");
    settle();

    // R3 refresh cycle time
    send(REF, 0, 0, 1'b1, "R3 ref");
    idle(13);
    send(REF, 0, 0, 1'b1, "R3 rfc boundary");
    idle(12);
    send(ACT, 0, 3, 1'b1, "R3 rfc act");
    settle();

    // R7 self-refresh exit
    send(SREX, 0, 0, 1'b1, "R7 srex");
    idle(13);
    send(ACT, 0, 2, 1'b1, "R7 non-read early");
    idle(184);
    send(RD, 0, 2, 1'b1, "R7 read early");
    send(RD, 0, 0, 1'b1, "R7 read boundary");
    settle();

    // R8 write to reactivate
    send(ACT, 0, 0, 1'b1, "R8 act");
    idle(7);
    send(WR, 0, 0, 1'b1, "R8 wr");
    idle(3);
    send(ACT, 0, 14, 1'b1, "R8 dal");
    settle();

    // R9 open too long, coincident with R10 priority
    send(ACT, 0, 0, 1'b1, "R9 act b0");
    idle(1);
    send(ACT, 1, 0, 1'b1, "R9 act b1");
    idle(23996);
    send(MRS, 0, 0, 1'b1, "R9 mrs");
    send(REF, 0, 1, 1'b1, "R10 mrd over rasmax");
    send(NOP, 0, 0, 1'b1, "R9 no repeat");
    send(NOP, 0, 15, 1'b1, "R9 rasmax b1");
    send(PREA, 0, 0, 1'b1, "R9 close");
    idle(4);

    finish_up();
  end
endmodule